// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block drains a ring of transmit descriptors that software places in shared memory. Software programs a descriptor base address, a status base address and the ring size (written as the descriptor count minus one), then advances a produce index each time it hands over a descriptor. The engine owns the consume index. Whenever work is pending and transmission is enabled, it fetches the descriptor's pointer and control words over a single-request memory port. It then streams the fragment's bytes out on a byte-wide valid/ready channel, writes a completion word into the status array and advances the consume index, which wraps to zero after the last slot.

Equal produce and consume indices are ambiguous, so the block keeps a separate full flag. The flag is set when a produce-index write catches up with the consume index, and cleared by the next consume advance. The controller is one state machine. Its states are IDLE, PTR (fetch pointer word), CTL (fetch control word), FETCH (fetch a data word), SEND (present bytes), STAT (write status) and ADV (advance index). The transitions are:

- IDLE to PTR when enabled with work pending.
- PTR to CTL, CTL to FETCH and FETCH to SEND, each on a memory acknowledge.
- SEND back to FETCH when the byte just accepted was the top lane of its word, and SEND to STAT when it was the final byte.
- STAT to ADV on acknowledge, and ADV to IDLE unconditionally.

Top module: `tx_ring_engine`

## Requirements
- R1: After reset the consume index, produce index and flags read 0, and `tx_valid`, `mem_req` and `irq_pulse` are low.
- R2: Register word offsets on `reg_addr` are 0 control (bit 0 = transmit enable), 1 descriptor base, 2 status base, 3 ring size minus one, 4 produce index, 5 consume index (read-only) and 6 flags (bit 0 = busy, bit 1 = full, read-only). Written values read back.
- R3: When the produce and consume indices are equal and the full flag is clear, no memory request is issued and no byte is offered.
- R4: A descriptor at slot n is fetched as two reads: the pointer word at descriptor base + 8n, then the control word at base + 8n + 4. A request holds its address until acknowledged.
- R5: The engine sends (control[10:0] + 1) bytes starting at the pointer address in ascending order, taking byte lane (address mod 4) of each 32-bit word, least significant byte as lane 0. A byte offered without `tx_ready` stays stable.
- R6: `tx_last` is high exactly on the final byte of a descriptor whose control bit 30 is set.
- R7: After the final byte, the engine writes the word {1, control[30], 19 zeros, control[10:0]} to status base + 4n.
- R8: The consume index advances only after that status write is acknowledged, and goes to 0 after the slot equal to the ring-size register.
- R9: A produce-index write that changes the index and makes it equal the consume index sets the full flag (flags bit 1). The engine then processes every descriptor, and the flag clears at the first consume advance.
- R10: `irq_pulse` is high for exactly one cycle when a descriptor with control bit 31 completes, and never otherwise.
- R11: With transmit enable low, the engine finishes the descriptor in progress, including its status write and advance, and then starts no new descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request completes this cycle |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Byte is offered |
| tx_last | output | 1 | Final byte of a last fragment |
| tx_ready | input | 1 | Downstream accepts the byte |
| irq_pulse | output | 1 | One-cycle completion interrupt |

## Verification
The bench drives the following corner cases:

- **Unaligned pointers and lane order.** A design with the wrong lane order or a missing refetch shows up as corrupted bytes.
- **Fragments crossing word boundaries under irregular `tx_ready`.** A design that drops a held byte shows up as missing or corrupted bytes.
- **Consume-index wrap past slot 3.** A wrong wrap sends the engine to a wrong descriptor.
- **A ring filled completely while disabled.** A design that takes equal indices as empty never sets the full flag and never transmits the queued descriptors.
- **Transmit enable dropped mid-fragment.** A design that aborts truncates the frame. A design that ignores the enable fetches the next descriptor.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] REG_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] REG_DESC  = 3'd1;
    localparam logic [REG_AW-1:0] REG_STAT  = 3'd2;
    localparam logic [REG_AW-1:0] REG_RING  = 3'd3;
    localparam logic [REG_AW-1:0] REG_PROD  = 3'd4;
    localparam logic [REG_AW-1:0] REG_CONS  = 3'd5;
    localparam logic [REG_AW-1:0] REG_FLAGS = 3'd6;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTL_LAST_BIT = 30;
    localparam int CTL_IRQ_BIT  = 31;
    localparam int FLAG_BUSY    = 0;
    localparam int FLAG_FULL    = 1;

    localparam int DESC_SHIFT = 3;   // two words per descriptor
    localparam int STAT_SHIFT = 2;   // one word per status entry

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PTR,
        ST_CTL,
        ST_FETCH,
        ST_SEND,
        ST_STAT,
        ST_ADV
    } tx_state_e;
endpackage

// File: rtl/tx_ring_regs.sv
module tx_ring_regs
    import tx_ring_pkg::*;
#(
    parameter int DW    = 32,
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic              cons_adv,
    input  logic              busy,
    output logic              tx_en,
    output logic [DW-1:0]     desc_base,
    output logic [DW-1:0]     stat_base,
    output logic [IDX_W-1:0]  cons_idx,
    output logic              pending
);
    logic [IDX_W-1:0] prod_q, cons_q, last_q, cons_after, new_prod;
    logic             full_q, en_q, prod_wr, full_set;
    logic [DW-1:0]    desc_q, stat_q;

    assign new_prod   = wdata[IDX_W-1:0];
    assign prod_wr    = wr && (addr == REG_PROD);
    assign cons_after = cons_adv ? ((cons_q == last_q) ? '0 : cons_q + 1'b1) : cons_q;
    assign full_set   = prod_wr && (new_prod != prod_q) && (new_prod == cons_after);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            desc_q <= '0;
            stat_q <= '0;
            last_q <= '0;
            prod_q <= '0;
            cons_q <= '0;
            full_q <= 1'b0;
        end else begin
            if (wr) begin
                case (addr)
                    REG_CTRL: en_q   <= wdata[CTRL_EN_BIT];
                    REG_DESC: desc_q <= wdata;
                    REG_STAT: stat_q <= wdata;
                    REG_RING: last_q <= wdata[IDX_W-1:0];
                    REG_PROD: prod_q <= new_prod;
                    default: ;
                endcase
            end
            cons_q <= cons_after;
            if (full_set)
                full_q <= 1'b1;
            else if (cons_adv)
                full_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            REG_CTRL:  rdata[CTRL_EN_BIT] = en_q;
            REG_DESC:  rdata = desc_q;
            REG_STAT:  rdata = stat_q;
            REG_RING:  rdata[IDX_W-1:0] = last_q;
            REG_PROD:  rdata[IDX_W-1:0] = prod_q;
            REG_CONS:  rdata[IDX_W-1:0] = cons_q;
            REG_FLAGS: begin
                rdata[FLAG_BUSY] = busy;
                rdata[FLAG_FULL] = full_q;
            end
            default:   rdata = '0;
        endcase
    end

    assign tx_en     = en_q;
    assign desc_base = desc_q;
    assign stat_base = stat_q;
    assign cons_idx  = cons_q;
    assign pending   = full_q || (prod_q != cons_q);

    // R8: an advance is only ever requested while work is outstanding
    assert_adv_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cons_adv |-> pending);
endmodule

// File: rtl/tx_ring_lane_mux.sv
module tx_ring_lane_mux #(
    parameter int DW = 32,
    localparam int LANES  = DW / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [DW-1:0]     word,
    input  logic [LANE_W-1:0] sel,
    output logic [7:0]        byte_out
);
    logic [7:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word[8*g +: 8];
    end

    assign byte_out = lanes[sel];
endmodule

// File: rtl/tx_ring_ctrl.sv
module tx_ring_ctrl
    import tx_ring_pkg::*;
#(
    parameter int DW    = 32,
    parameter int IDX_W = 8,
    parameter int LEN_W = 11,
    localparam int LANE_W = $clog2(DW / 8),
    localparam int REM_W  = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             pending,
    input  logic [DW-1:0]    desc_base,
    input  logic [DW-1:0]    stat_base,
    input  logic [IDX_W-1:0] cons_idx,
    output logic             mem_req,
    output logic             mem_we,
    output logic [DW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_ack,
    output logic [7:0]       tx_data,
    output logic             tx_valid,
    output logic             tx_last,
    input  logic             tx_ready,
    output logic             cons_adv,
    output logic             irq_pulse,
    output logic             busy
);
    tx_state_e        state_q, state_d;
    logic [DW-1:0]    ptr_q, word_q;
    logic [LEN_W-1:0] len_q;
    logic             last_q, irq_q;
    logic [REM_W-1:0] remain_q;
    logic [DW-1:0]    slot_desc, slot_stat;
    logic             final_byte, word_end;

    assign slot_desc  = desc_base + (DW'(cons_idx) << DESC_SHIFT);
    assign slot_stat  = stat_base + (DW'(cons_idx) << STAT_SHIFT);
    assign final_byte = (remain_q == REM_W'(1));
    assign word_end   = &ptr_q[LANE_W-1:0];

    tx_ring_lane_mux #(.DW(DW)) u_lane (
        .word    (word_q),
        .sel     (ptr_q[LANE_W-1:0]),
        .byte_out(tx_data)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tx_en && pending) state_d = ST_PTR;
            ST_PTR:   if (mem_ack) state_d = ST_CTL;
            ST_CTL:   if (mem_ack) state_d = ST_FETCH;
            ST_FETCH: if (mem_ack) state_d = ST_SEND;
            ST_SEND: begin
                if (tx_ready) begin
                    if (final_byte)    state_d = ST_STAT;
                    else if (word_end) state_d = ST_FETCH;
                end
            end
            ST_STAT:  if (mem_ack) state_d = ST_ADV;
            ST_ADV:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // descriptor and data holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            word_q   <= '0;
            len_q    <= '0;
            last_q   <= 1'b0;
            irq_q    <= 1'b0;
            remain_q <= '0;
        end else begin
            unique case (state_q)
                ST_PTR: if (mem_ack) ptr_q <= mem_rdata;
                ST_CTL: if (mem_ack) begin
                    len_q    <= mem_rdata[LEN_W-1:0];
                    last_q   <= mem_rdata[CTL_LAST_BIT];
                    irq_q    <= mem_rdata[CTL_IRQ_BIT];
                    remain_q <= REM_W'(mem_rdata[LEN_W-1:0]) + REM_W'(1);
                end
                ST_FETCH: if (mem_ack) word_q <= mem_rdata;
                ST_SEND: if (tx_ready) begin
                    ptr_q    <= ptr_q + DW'(1);
                    remain_q <= remain_q - REM_W'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        tx_valid  = 1'b0;
        tx_last   = 1'b0;
        cons_adv  = 1'b0;
        irq_pulse = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PTR: begin
                mem_req  = 1'b1;
                mem_addr = slot_desc;
            end
            ST_CTL: begin
                mem_req  = 1'b1;
                mem_addr = slot_desc + DW'(4);
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = {ptr_q[DW-1:LANE_W], {LANE_W{1'b0}}};
            end
            ST_SEND: begin
                tx_valid = 1'b1;
                tx_last  = final_byte && last_q;
            end
            ST_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = slot_stat;
                mem_wdata = {1'b1, last_q, {(DW-2-LEN_W){1'b0}}, len_q};
            end
            ST_ADV: begin
                cons_adv  = 1'b1;
                irq_pulse = irq_q;
            end
            default: ;
        endcase
    end

    assign busy = (state_q != ST_IDLE);

    // R5: an offered byte is held until accepted
    assert_hold_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
    // R4: a memory request keeps its address until acknowledged
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
    // R10: the interrupt is a single-cycle pulse
    assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);
    // R11: idle and disabled means no memory traffic next cycle
    assert_halt_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en && !busy |=> !mem_req);
    // R3: idle with an empty ring issues no request
    assert_empty_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pending && !busy |=> !mem_req && !tx_valid);
endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine
    import tx_ring_pkg::*;
#(
    parameter int DW    = 32,
    parameter int IDX_W = 8,
    parameter int LEN_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_ack,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              irq_pulse
);
    logic             tx_en, pending, cons_adv, busy;
    logic [DW-1:0]    desc_base, stat_base;
    logic [IDX_W-1:0] cons_idx;

    tx_ring_regs #(.DW(DW), .IDX_W(IDX_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .cons_adv (cons_adv),
        .busy     (busy),
        .tx_en    (tx_en),
        .desc_base(desc_base),
        .stat_base(stat_base),
        .cons_idx (cons_idx),
        .pending  (pending)
    );

    tx_ring_ctrl #(.DW(DW), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .pending  (pending),
        .desc_base(desc_base),
        .stat_base(stat_base),
        .cons_idx (cons_idx),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata),
        .mem_ack  (mem_ack),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_last  (tx_last),
        .tx_ready (tx_ready),
        .cons_adv (cons_adv),
        .irq_pulse(irq_pulse),
        .busy     (busy)
    );

    // R8: the consume index moves two cycles after an acknowledged status write
    assert_cons_after_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_idx != $past(cons_idx)) |-> $past(mem_req && mem_we && mem_ack, 2));
endmodule

// File: tb/tx_ring_engine_test.sv
`timescale 1ns/1ps
module tx_ring_engine_test;
    localparam int NVEC = 6;
    localparam int WD_CYCLES = 200000;
    localparam logic [31:0] DESC_BASE = 32'h100;
    localparam logic [31:0] STAT_BASE = 32'h200;
    localparam logic [31:0] VEC_PTR [NVEC] = '{32'h300, 32'h305, 32'h012, 32'h020, 32'h3F0, 32'h041};
    localparam logic [31:0] VEC_CTL [NVEC] = '{32'h4000_0003, 32'h8000_0005, 32'hC000_0000,
                                              32'h4000_0008, 32'h8000_000F, 32'h0000_0002};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_last;
    logic        tx_ready = 1'b0;
    logic        irq_pulse;

    logic [31:0] mem [256];
    logic [31:0] rd_hist [64];
    int          rd_count = 0;
    int          irq_count = 0;
    logic        bd_init = 1'b1;
    logic        bd_we = 1'b0;
    logic [31:0] bd_addr = '0, bd_data = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tx_ring_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
        .irq_pulse(irq_pulse)
    );

    function automatic logic [7:0] pat(input logic [31:0] a);
        return 8'((a * 7) + 3);
    endfunction

    // memory model and monitors, all at the falling edge
    always @(negedge clk) begin
        if (bd_init) begin
            for (int w = 0; w < 256; w++)
                mem[w] <= {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
        end else if (bd_we) begin
            mem[bd_addr[9:2]] <= bd_data;
        end
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[9:2]] <= mem_wdata;
            end else begin
                mem_rdata <= mem[mem_addr[9:2]];
                rd_hist[rd_count % 64] <= mem_addr;
                rd_count <= rd_count + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
        if (irq_pulse) irq_count <= irq_count + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic bd_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        #1 bd_we = 1'b1; bd_addr = a; bd_data = d;
        @(negedge clk);
        #1 bd_we = 1'b0;
    endtask

    task automatic put_desc(input int slot, input logic [31:0] p, input logic [31:0] c);
        bd_write(DESC_BASE + 32'(8*slot), p);
        bd_write(DESC_BASE + 32'(8*slot) + 32'd4, c);
    endtask

    task automatic recv_frame(input logic [31:0] p, input logic [31:0] c, input int seed, input string tag);
        int n, k, tick, bad_data, bad_last;
        logic [31:0] first_bad;
        n = int'(c[10:0]) + 1; k = 0; tick = 0; bad_data = 0; bad_last = 0; first_bad = '0;
        while (k < n && tick < 20000) begin
            @(negedge clk);
            tx_ready = ((tick + seed) % 3) != 0;
            tick++;
            #1;
            if (tx_valid && tx_ready) begin
                if (tx_data !== pat(p + 32'(k))) begin
                    if (bad_data == 0) first_bad = {24'd0, tx_data};
                    bad_data++;
                end
                if (tx_last !== ((k == n-1) && c[30])) bad_last++;
                k++;
            end
        end
        chk(k == n && bad_data == 0, {"R5 bytes ", tag}, first_bad, 32'(k));
        chk(bad_last == 0, {"R6 last flag ", tag}, 32'(bad_last), 32'd0);
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic wait_cons(input logic [31:0] exp, input string tag);
        logic [31:0] v;
        v = '0;
        for (int t = 0; t < 100; t++) begin
            rd_reg(3'd5, v);
            if (v == exp) break;
        end
        chk(v == exp, {"R8 consume index ", tag}, v, exp);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R11 act=%0d exp=finish", WD_CYCLES);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int snap_rd, snap_irq, slot;
        @(negedge clk);
        @(negedge clk);
        bd_init = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state, sampled while reset is held
        chk(tx_valid == 0 && mem_req == 0 && irq_pulse == 0, "R1 outputs in reset",
            {29'd0, tx_valid, mem_req, irq_pulse}, 32'd0);
        rst_n = 1'b1;
        rd_reg(3'd5, v); chk(v == 0, "R1 consume index", v, 0);
        rd_reg(3'd4, v); chk(v == 0, "R1 produce index", v, 0);
        rd_reg(3'd6, v); chk(v == 0, "R1 flags", v, 0);

        // R2 programming and read-back
        wr_reg(3'd1, DESC_BASE);
        wr_reg(3'd2, STAT_BASE);
        wr_reg(3'd3, 32'd3);
        wr_reg(3'd0, 32'd1);
        rd_reg(3'd3, v); chk(v == 3, "R2 ring size", v, 3);
        rd_reg(3'd1, v); chk(v == DESC_BASE, "R2 desc base", v, DESC_BASE);
        rd_reg(3'd0, v); chk(v == 1, "R2 enable", v, 1);

        // R3 empty ring: nothing happens
        snap_rd = rd_count;
        repeat (30) @(negedge clk);
        #1;
        chk(rd_count == snap_rd && !tx_valid, "R3 empty ring quiet", 32'(rd_count - snap_rd), 0);
        rd_reg(3'd6, v); chk(v == 0, "R3 flags empty", v, 0);

        // vector table walk
        for (int i = 0; i < NVEC; i++) begin
            slot = i % 4;
            put_desc(slot, VEC_PTR[i], VEC_CTL[i]);
            snap_rd = rd_count;
            snap_irq = irq_count;
            wr_reg(3'd4, 32'((i + 1) % 4));
            recv_frame(VEC_PTR[i], VEC_CTL[i], i, $sformatf("vec%0d", i));
            wait_cons(32'((i + 1) % 4), $sformatf("vec%0d", i));
            chk(rd_hist[snap_rd % 64] == DESC_BASE + 32'(8*slot), "R4 pointer fetch addr",
                rd_hist[snap_rd % 64], DESC_BASE + 32'(8*slot));
            chk(rd_hist[(snap_rd + 1) % 64] == DESC_BASE + 32'(8*slot) + 4, "R4 control fetch addr",
                rd_hist[(snap_rd + 1) % 64], DESC_BASE + 32'(8*slot) + 4);
            v = {1'b1, VEC_CTL[i][30], 19'd0, VEC_CTL[i][10:0]};
            chk(mem[(STAT_BASE[9:2]) + 8'(slot)] == v, "R7 status word",
                mem[(STAT_BASE[9:2]) + 8'(slot)], v);
            chk((irq_count - snap_irq) == int'(VEC_CTL[i][31]), "R10 interrupt count",
                32'(irq_count - snap_irq), {31'd0, VEC_CTL[i][31]});
        end

        // R9 fill the whole ring while disabled; consume index is 2
        wr_reg(3'd0, 32'd0);
        for (int j = 0; j < 4; j++)
            put_desc((2 + j) % 4, 32'h300 + 32'(16*j), 32'h4000_0001);
        snap_rd = rd_count;
        wr_reg(3'd4, 32'd3);
        wr_reg(3'd4, 32'd0);
        wr_reg(3'd4, 32'd1);
        wr_reg(3'd4, 32'd2);
        repeat (10) @(negedge clk);
        rd_reg(3'd6, v); chk(v == 32'd2, "R9 full flag set", v, 2);
        chk(rd_count == snap_rd, "R11 disabled issues no reads", 32'(rd_count - snap_rd), 0);
        wr_reg(3'd0, 32'd1);
        for (int j = 0; j < 4; j++)
            recv_frame(32'h300 + 32'(16*j), 32'h4000_0001, j, $sformatf("full%0d", j));
        wait_cons(32'd2, "after full drain");
        rd_reg(3'd6, v); chk(v == 0, "R9 full flag cleared", v, 0);

        // R11 drop enable mid-fragment
        put_desc(2, 32'h300, 32'h4000_0007);
        put_desc(3, 32'h341, 32'h4000_0001);
        wr_reg(3'd4, 32'd0);
        for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            if (tx_valid) break;
        end
        wr_reg(3'd0, 32'd0);
        recv_frame(32'h300, 32'h4000_0007, 1, "R11 current frame");
        wait_cons(32'd3, "R11 finish");
        snap_rd = rd_count;
        repeat (30) @(negedge clk);
        #1;
        chk(rd_count == snap_rd && !tx_valid, "R11 stopped after current", 32'(rd_count - snap_rd), 0);
        rd_reg(3'd5, v); chk(v == 3, "R11 consume held", v, 3);
        wr_reg(3'd0, 32'd1);
        recv_frame(32'h341, 32'h4000_0001, 2, "R11 resume");
        wait_cons(32'd0, "R11 resume");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule